// File: doc/BRIEF.md
# Dual-Mode Parity/ECC Pair Controller

This block is the datapath of a memory controller. It keeps one 64-bit logical word as two 32-bit halves in a pair of 36-bit banks. Each bank has 32 data bits and four spare bit lanes, one lane beside each byte. A configuration input picks the mode at run time, and no hardware change is needed. In byte-parity mode every spare lane holds the parity of its own byte. In combined ECC mode the eight spare lanes of the pair hold eight check bits of a 64-bit single-error-correct, double-error-detect code.

ECC mode is granted only while the two banks are flagged as a matched pair. Otherwise the block falls back to parity. Reads are checked on the way back. Parity mismatches and uncorrectable ECC faults raise a one-cycle non-maskable interrupt request. An uncorrectable ECC fault also marks the pair as deallocated.

In ECC mode a write that does not cover all eight bytes becomes a read-modify-write. The block reads the pair, corrects it, merges the new bytes, re-encodes the word and writes all lanes back.

The bank port has a one-cycle read latency. Read data appears on the cycle after the read strobe. A write takes effect at the clock edge where the write strobe is high, for each lane whose enable is set.

Top module: `pair_mem_ctrl`

## Requirements
- R1: A request runs in ECC mode only when `cfg_ecc_en` and `cfg_pair_matched` are both 1 at the cycle it is accepted. Otherwise it runs in parity mode, with parity lanes and parity-mode latency.
- R2: In a parity-mode write, spare bit 32+k of each bank holds the XOR of that bank's data byte k (even parity). `mem_lo_lanes` follows `req_be[3:0]` (word bytes 0-3, low bank) and `mem_hi_lanes` follows `req_be[7:4]` (word bytes 4-7, high bank).
- R3: In a parity-mode read, the response carries the raw bank data, with word bits 31:0 from the low bank. Any byte mismatch sets `rsp_fault` and `nmi_req` in the response cycle, and `rsp_fixed` stays 0. Two flipped bits within one byte are not detected.
- R4: In an ECC-mode write of all eight bytes, all eight lanes of both banks are written in a single cycle. Check bits 0-3 go to low-bank spare bits 35:32 and check bits 4-7 go to high-bank spare bits 35:32.
- R5: In an ECC-mode read, a single flipped bit anywhere among the 72 stored bits is corrected in `rsp_rdata`. The response sets `rsp_fixed`, leaves `rsp_fault` at 0 and raises no `nmi_req`.
- R6: In an ECC-mode read, two flipped bits set `rsp_fault` and `nmi_req`. They also set `pair_dealloc`, which then stays 1 until reset.
- R7: After acceptance, a parity-mode read responds on the second clock edge and an ECC-mode read on the third.
- R8: In ECC mode, a write with any byte enable clear reads the pair, corrects it and merges the enabled new bytes over the corrected old ones. It then writes the re-encoded word to all lanes. `req_ready` is low for the three cycles this takes, and a single flipped bit in an unwritten byte is repaired in the stored result.
- R9: If the old word of a read-modify-write is uncorrectable, nothing is written back. The block raises `nmi_req` and sets `pair_dealloc`.
- R10: After reset, `req_ready` is 1, and `rsp_valid`, `nmi_req`, `pair_dealloc`, `mem_re` and `mem_we` are 0.
- R11: A parity-mode fault never sets `pair_dealloc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ecc_en | input | 1 | Requests ECC mode |
| cfg_pair_matched | input | 1 | Banks form a matched pair |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables of the write |
| rsp_valid | output | 1 | Read response this cycle |
| rsp_rdata | output | 64 | Read data (corrected in ECC mode) |
| rsp_fixed | output | 1 | A single-bit error was corrected |
| rsp_fault | output | 1 | Detected error not corrected |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| pair_dealloc | output | 1 | Sticky: the pair is taken out of service |
| mem_addr | output | ADDR_W | Bank address |
| mem_re | output | 1 | Bank read strobe |
| mem_we | output | 1 | Bank write strobe |
| mem_lo_lanes | output | 4 | Low-bank lane write enables |
| mem_hi_lanes | output | 4 | High-bank lane write enables |
| mem_lo_wdata | output | 36 | Low-bank write data, spares in 35:32 |
| mem_hi_wdata | output | 36 | High-bank write data, spares in 35:32 |
| mem_lo_rdata | input | 36 | Low-bank read data |
| mem_hi_rdata | input | 36 | High-bank read data |

## Verification
In one decode cycle of a partial ECC write, the single-bit correction of the old word and the byte merge of the new data both take place. The bench provokes this by flipping one stored bit first in a byte the write leaves alone and then in a byte it overwrites. In each case it compares the bank contents and a later clean read against its own merged value. It also judges the abort path, in which the same cycle finds an uncorrectable old word and must suppress the write-back while raising the interrupt.

// File: rtl/pmc_pkg.sv
// pmc_pkg: shared widths, controller states and the code-construction
// functions of the 64-bit SEC-DED code.
// Assumes: data bit d sits at the d-th Hamming position that is not a
// power of two (positions 3..71); check bit i (i<7) covers positions with
// bit i set; check bit 7 is overall parity of data and check bits 0..6.
package pmc_pkg;

    localparam int HALF_W = 32;
    localparam int LANES  = HALF_W / 8;
    localparam int BANK_W = HALF_W + LANES;
    localparam int WORD_W = 2 * HALF_W;
    localparam int WBYTES = WORD_W / 8;
    localparam int HAM_W  = 7;
    localparam int CHK_W  = HAM_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_DEC,
        ST_RMW_RD,
        ST_RMW_DEC,
        ST_RMW_WR
    } pmc_state_e;

    // Hamming position of data bit d.
    function automatic logic [HAM_W-1:0] hpos(int unsigned d);
        int unsigned n;
        logic [HAM_W-1:0] p;
        n = 0;
        p = '0;
        for (int unsigned q = 3; q < 128; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == d) p = q[HAM_W-1:0];
                n++;
            end
        end
        return p;
    endfunction

    // Data bits covered by Hamming check bit i.
    function automatic logic [WORD_W-1:0] chk_mask(int unsigned i);
        logic [WORD_W-1:0] m;
        logic [HAM_W-1:0] p;
        m = '0;
        for (int unsigned d = 0; d < WORD_W; d++) begin
            p = hpos(d);
            m[d] = p[i];
        end
        return m;
    endfunction

endpackage

// File: rtl/pmc_byte_par.sv
// pmc_byte_par: even parity of each byte of a bank half.
// Assumes: the data width is a whole number of bytes.
module pmc_byte_par #(
    parameter int NLANES = 4
) (
    input  logic [NLANES*8-1:0] data,
    output logic [NLANES-1:0]   par
);
    // One XOR tree per byte lane.
    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        assign par[k] = ^data[8*k +: 8];
    end
endmodule

// File: rtl/pmc_secded_enc.sv
// pmc_secded_enc: computes the 8 check bits of a 64-bit word.
// Assumes the construction described in pmc_pkg.
module pmc_secded_enc
    import pmc_pkg::*;
(
    input  logic [WORD_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    logic [HAM_W-1:0] ham;

    // Hamming check bits, one masked XOR per bit.
    for (genvar i = 0; i < HAM_W; i++) begin : g_ham
        localparam logic [WORD_W-1:0] MASK = chk_mask(i);
        assign ham[i] = ^(data & MASK);
    end

    // Overall parity completes the double-error detection.
    assign chk = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/pmc_secded_dec.sv
// pmc_secded_dec: syndrome decode and single-bit correction of a 64-bit word.
// Assumes the construction described in pmc_pkg. Purely combinational.
module pmc_secded_dec
    import pmc_pkg::*;
(
    input  logic [WORD_W-1:0] data,
    input  logic [CHK_W-1:0]  chk,
    output logic [WORD_W-1:0] fixed_data,
    output logic [WORD_W-1:0] flip,
    output logic              err_fixed,
    output logic              err_fatal
);
    logic [HAM_W-1:0] syn;
    logic             odd;
    logic             pos_ok;

    // Syndrome against recomputed Hamming bits.
    for (genvar i = 0; i < HAM_W; i++) begin : g_syn
        localparam logic [WORD_W-1:0] MASK = chk_mask(i);
        assign syn[i] = (^(data & MASK)) ^ chk[i];
    end

    // Data bit flip when an odd error points at its position.
    for (genvar k = 0; k < WORD_W; k++) begin : g_flip
        localparam logic [HAM_W-1:0] POS = hpos(k);
        assign flip[k] = odd && (syn == POS);
    end

    assign odd        = (^data) ^ (^chk);
    assign pos_ok     = (syn == '0) || $onehot(syn) || (|flip);
    assign fixed_data = data ^ flip;
    assign err_fixed  = odd && pos_ok;
    assign err_fatal  = (!odd && (syn != '0)) || (odd && !pos_ok);
endmodule

// File: rtl/pair_mem_ctrl.sv
// pair_mem_ctrl: parity / combined-ECC controller for a matched bank pair.
// A 64-bit word is held as two 36-bit bank words (data 31:0, spares 35:32).
// Assumes: banks return read data one cycle after mem_re; writes land at the
// edge where mem_we is high for each enabled lane; one request in flight.
module pair_mem_ctrl
    import pmc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ecc_en,
    input  logic              cfg_pair_matched,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [7:0]        req_be,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_fixed,
    output logic              rsp_fault,
    output logic              nmi_req,
    output logic              pair_dealloc,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [3:0]        mem_lo_lanes,
    output logic [3:0]        mem_hi_lanes,
    output logic [35:0]       mem_lo_wdata,
    output logic [35:0]       mem_hi_wdata,
    input  logic [35:0]       mem_lo_rdata,
    input  logic [35:0]       mem_hi_rdata
);
    localparam int HC = CHK_W / 2;

    pmc_state_e          state;
    logic [ADDR_W-1:0]   op_addr;
    logic [WORD_W-1:0]   op_wdata;
    logic [WBYTES-1:0]   op_be;
    logic                op_ecc;
    logic [BANK_W-1:0]   raw_lo, raw_hi;
    logic [WORD_W-1:0]   merged;

    logic                eff_ecc, accept, partial, rmw_start, wr_ecc;
    logic [WORD_W-1:0]   wr_word;
    logic [CHK_W-1:0]    wr_chk;
    logic [LANES-1:0]    wpar_lo, wpar_hi, rpar_lo, rpar_hi;
    logic                par_bad;
    logic [WORD_W-1:0]   dec_q, dec_flip, merge_c;
    logic                dec_fixed, dec_fatal;

    // Request acceptance and mode grant.
    assign eff_ecc   = cfg_ecc_en && cfg_pair_matched;
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign partial   = !(&req_be);
    assign rmw_start = accept && req_write && eff_ecc && partial;

    // Bank strobes and address.
    assign mem_re   = accept && (!req_write || rmw_start);
    assign mem_we   = (accept && req_write && !rmw_start) || (state == ST_RMW_WR);
    assign mem_addr = (state == ST_IDLE) ? req_addr : op_addr;

    // Write word source: host data or merged read-modify-write word.
    assign wr_word = (state == ST_RMW_WR) ? merged : req_wdata;
    assign wr_ecc  = (state == ST_RMW_WR) ? 1'b1 : eff_ecc;

    pmc_secded_enc u_enc (.data(wr_word), .chk(wr_chk));

    pmc_byte_par #(.NLANES(LANES)) u_wpar_lo (.data(wr_word[HALF_W-1:0]),      .par(wpar_lo));
    pmc_byte_par #(.NLANES(LANES)) u_wpar_hi (.data(wr_word[WORD_W-1:HALF_W]), .par(wpar_hi));
    pmc_byte_par #(.NLANES(LANES)) u_rpar_lo (.data(mem_lo_rdata[HALF_W-1:0]), .par(rpar_lo));
    pmc_byte_par #(.NLANES(LANES)) u_rpar_hi (.data(mem_hi_rdata[HALF_W-1:0]), .par(rpar_hi));

    // Spare lanes carry parity or check bits depending on the mode.
    always_comb begin
        mem_lo_wdata = {wr_ecc ? wr_chk[HC-1:0]     : wpar_lo, wr_word[HALF_W-1:0]};
        mem_hi_wdata = {wr_ecc ? wr_chk[CHK_W-1:HC] : wpar_hi, wr_word[WORD_W-1:HALF_W]};
    end

    // Lane enables: every lane in ECC mode, byte enables in parity mode.
    always_comb begin
        mem_lo_lanes = '0;
        mem_hi_lanes = '0;
        if (mem_we) begin
            mem_lo_lanes = wr_ecc ? '1 : req_be[LANES-1:0];
            mem_hi_lanes = wr_ecc ? '1 : req_be[WBYTES-1:LANES];
        end
    end

    // Parity check of the returning bank words.
    assign par_bad = |{rpar_lo ^ mem_lo_rdata[BANK_W-1:HALF_W],
                       rpar_hi ^ mem_hi_rdata[BANK_W-1:HALF_W]};

    pmc_secded_dec u_dec (
        .data      ({raw_hi[HALF_W-1:0], raw_lo[HALF_W-1:0]}),
        .chk       ({raw_hi[BANK_W-1:HALF_W], raw_lo[BANK_W-1:HALF_W]}),
        .fixed_data(dec_q),
        .flip      (dec_flip),
        .err_fixed (dec_fixed),
        .err_fatal (dec_fatal)
    );

    // Byte merge of new write data over the corrected old word.
    always_comb begin
        for (int b = 0; b < WBYTES; b++) begin
            merge_c[8*b +: 8] = op_be[b] ? op_wdata[8*b +: 8] : dec_q[8*b +: 8];
        end
    end

    // Sequencer, response registers and fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            op_addr      <= '0;
            op_wdata     <= '0;
            op_be        <= '0;
            op_ecc       <= 1'b0;
            raw_lo       <= '0;
            raw_hi       <= '0;
            merged       <= '0;
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_fixed    <= 1'b0;
            rsp_fault    <= 1'b0;
            nmi_req      <= 1'b0;
            pair_dealloc <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            nmi_req   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        op_addr  <= req_addr;
                        op_wdata <= req_wdata;
                        op_be    <= req_be;
                        op_ecc   <= eff_ecc;
                        if (!req_write)     state <= ST_RD;
                        else if (rmw_start) state <= ST_RMW_RD;
                    end
                end
                ST_RD: begin
                    if (op_ecc) begin
                        raw_lo <= mem_lo_rdata;
                        raw_hi <= mem_hi_rdata;
                        state  <= ST_RD_DEC;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= {mem_hi_rdata[HALF_W-1:0], mem_lo_rdata[HALF_W-1:0]};
                        rsp_fixed <= 1'b0;
                        rsp_fault <= par_bad;
                        nmi_req   <= par_bad;
                        state     <= ST_IDLE;
                    end
                end
                ST_RD_DEC: begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= dec_q;
                    rsp_fixed <= dec_fixed;
                    rsp_fault <= dec_fatal;
                    nmi_req   <= dec_fatal;
                    if (dec_fatal) pair_dealloc <= 1'b1;
                    state     <= ST_IDLE;
                end
                ST_RMW_RD: begin
                    raw_lo <= mem_lo_rdata;
                    raw_hi <= mem_hi_rdata;
                    state  <= ST_RMW_DEC;
                end
                ST_RMW_DEC: begin
                    if (dec_fatal) begin
                        nmi_req      <= 1'b1;
                        pair_dealloc <= 1'b1;
                        state        <= ST_IDLE;
                    end else begin
                        merged <= merge_c;
                        state  <= ST_RMW_WR;
                    end
                end
                ST_RMW_WR: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Deallocation is permanent until reset.
    assert_dealloc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_dealloc |=> pair_dealloc);

    // Deallocation is always announced by an interrupt request.
    assert_dealloc_with_nmi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pair_dealloc) |-> nmi_req);

    // Parity responses never claim a correction.
    assert_parity_no_fix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !op_ecc) |-> !rsp_fixed);

    // A corrected response is never also a fault.
    assert_fix_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_fixed && rsp_fault));

    // At most one data bit is flipped by the corrector.
    assert_single_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_flip));

    // An uncorrectable old word suppresses the write-back.
    assert_rmw_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RMW_DEC && dec_fatal) |=> !mem_we);

    // Read and write strobes never overlap on the bank port.
    assert_bank_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

endmodule

// File: tb/tb_pair_mem_ctrl.sv
module tb_pair_mem_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_ecc_en = 1'b0, cfg_pair_matched = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0] req_be = '0;
    logic req_ready, rsp_valid, rsp_fixed, rsp_fault, nmi_req, pair_dealloc;
    logic [63:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_re, mem_we;
    logic [3:0] mem_lo_lanes, mem_hi_lanes;
    logic [35:0] mem_lo_wdata, mem_hi_wdata;
    logic [35:0] mem_lo_rdata = '0, mem_hi_rdata = '0;

    logic [35:0] bank_lo [DEPTH];
    logic [35:0] bank_hi [DEPTH];
    logic [63:0] ref_mem [DEPTH];

    int n_chk = 0, n_fail = 0, nmi_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_mem_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en), .cfg_pair_matched(cfg_pair_matched),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_fixed(rsp_fixed), .rsp_fault(rsp_fault), .nmi_req(nmi_req), .pair_dealloc(pair_dealloc),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_lo_lanes(mem_lo_lanes),
        .mem_hi_lanes(mem_hi_lanes), .mem_lo_wdata(mem_lo_wdata), .mem_hi_wdata(mem_hi_wdata),
        .mem_lo_rdata(mem_lo_rdata), .mem_hi_rdata(mem_hi_rdata));

    // Bank pair model: lane k = data byte k plus spare bit 32+k.
    always @(posedge clk) begin
        if (mem_we) begin
            for (int k = 0; k < 4; k++) begin
                if (mem_lo_lanes[k]) begin
                    bank_lo[mem_addr][8*k +: 8] <= mem_lo_wdata[8*k +: 8];
                    bank_lo[mem_addr][32+k]     <= mem_lo_wdata[32+k];
                end
                if (mem_hi_lanes[k]) begin
                    bank_hi[mem_addr][8*k +: 8] <= mem_hi_wdata[8*k +: 8];
                    bank_hi[mem_addr][32+k]     <= mem_hi_wdata[32+k];
                end
            end
        end
        if (mem_re) begin
            mem_lo_rdata <= bank_lo[mem_addr];
            mem_hi_rdata <= bank_hi[mem_addr];
        end
    end

    always @(negedge clk) if (nmi_req) nmi_cnt++;

    function automatic logic [3:0] bpar(input logic [31:0] d);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = ^d[8*k +: 8];
        return p;
    endfunction

    function automatic logic [63:0] bmerge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
        return r;
    endfunction

    function automatic logic [63:0] bank_word(input int a);
        return {bank_hi[a][31:0], bank_lo[a][31:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Flip stored bit p: 0-31 low data, 32-63 high data, 64+j check/spare j.
    task automatic flip(input int a, input int p);
        if (p < 32)      bank_lo[a][p]      = ~bank_lo[a][p];
        else if (p < 64) bank_hi[a][p-32]   = ~bank_hi[a][p-32];
        else if (p < 68) bank_lo[a][p-32]   = ~bank_lo[a][p-32];
        else             bank_hi[a][p-36]   = ~bank_hi[a][p-36];
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [63:0] d, input logic [7:0] be, output int busy);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        busy = 0;
        while (!req_ready && busy < 20) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input int a, output logic [63:0] d, output bit fx, output bit ft,
                           output bit nm, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        d = rsp_rdata; fx = rsp_fixed; ft = rsp_fault; nm = nmi_req;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d, exp, nd, old;
        logic [35:0] slo, shi;
        bit fx, ft, nm;
        int lat, busy, a, n0, p1, p2;
        logic [7:0] be;
        void'($urandom(32'd7741));
        for (int i = 0; i < DEPTH; i++) begin bank_lo[i] = '0; bank_hi[i] = '0; end

        // R10 reset state
        do_reset();
        check(req_ready && !rsp_valid && !nmi_req && !pair_dealloc && !mem_re && !mem_we,
              "R10 reset outputs", {66'd0, req_ready, rsp_valid, nmi_req, pair_dealloc, mem_re, mem_we},
              72'b100000);

        // Parity mode: initialise, then random traffic.
        cfg_ecc_en = 1'b0; cfg_pair_matched = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = {$urandom, $urandom};
            do_write(i, ref_mem[i], 8'hFF, busy);
        end
        for (int it = 0; it < 60; it++) begin
            a = $urandom_range(DEPTH-1);
            if ($urandom_range(1) == 1) begin
                nd = {$urandom, $urandom}; be = 8'($urandom);
                do_write(a, nd, be, busy);
                ref_mem[a] = bmerge(ref_mem[a], nd, be);
                check(bank_word(a) == ref_mem[a], "R2 parity byte-enabled write",
                      {8'd0, bank_word(a)}, {8'd0, ref_mem[a]});
                check(bank_lo[a][35:32] == bpar(bank_lo[a][31:0]) && bank_hi[a][35:32] == bpar(bank_hi[a][31:0]),
                      "R2 parity lanes", {64'd0, bank_hi[a][35:32], bank_lo[a][35:32]},
                      {64'd0, bpar(bank_hi[a][31:0]), bpar(bank_lo[a][31:0])});
            end else begin
                do_read(a, d, fx, ft, nm, lat);
                check(d == ref_mem[a] && !ft && !fx, "R3 parity clean read",
                      {6'd0, fx, ft, d}, {8'd0, ref_mem[a]});
                check(lat == 2, "R7 parity read latency", 72'(lat), 72'd2);
            end
        end

        // R3 / R11 single flip in parity mode.
        n0 = nmi_cnt;
        flip(3, 13);
        do_read(3, d, fx, ft, nm, lat);
        exp = ref_mem[3] ^ (64'd1 << 13);
        check(d == exp && ft && nm && !fx, "R3 parity error flagged", {6'd0, fx, ft, d}, {8'b01, exp});
        @(negedge clk);
        check(nmi_cnt == n0 + 1, "R3 single nmi pulse", 72'(nmi_cnt - n0), 72'd1);
        check(!pair_dealloc, "R11 parity fault no dealloc", {71'd0, pair_dealloc}, 72'd0);
        flip(3, 13);
        // R3 two flips in one byte pass undetected.
        flip(4, 40); flip(4, 43);
        do_read(4, d, fx, ft, nm, lat);
        exp = ref_mem[4] ^ (64'd1 << 40) ^ (64'd1 << 43);
        check(d == exp && !ft && !nm, "R3 double in byte undetected", {6'd0, nm, ft, d}, {8'd0, exp});
        flip(4, 40); flip(4, 43);

        // R1 fallback: ECC requested but pair unmatched.
        cfg_ecc_en = 1'b1; cfg_pair_matched = 1'b0;
        ref_mem[5] = 64'hA5A5_0F0F_1234_8001;
        do_write(5, ref_mem[5], 8'hFF, busy);
        check(bank_lo[5][35:32] == bpar(bank_lo[5][31:0]) && bank_hi[5][35:32] == bpar(bank_hi[5][31:0]),
              "R1 unmatched falls back to parity lanes", {64'd0, bank_hi[5][35:32], bank_lo[5][35:32]},
              {64'd0, bpar(bank_hi[5][31:0]), bpar(bank_lo[5][31:0])});
        do_read(5, d, fx, ft, nm, lat);
        check(lat == 2 && d == ref_mem[5], "R1 unmatched parity latency", {8'(lat), d}, {8'd2, ref_mem[5]});
        be = 8'h0F;
        do_write(5, 64'hFFFF_FFFF_FFFF_FFFF, be, busy);
        check(busy == 0, "R1 unmatched partial write is direct", 72'(busy), 72'd0);
        ref_mem[5] = bmerge(ref_mem[5], 64'hFFFF_FFFF_FFFF_FFFF, be);

        // ECC mode on matched pair.
        cfg_pair_matched = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = {$urandom, $urandom};
            slo = bank_lo[i]; shi = bank_hi[i];
            do_write(i, ref_mem[i], 8'hFF, busy);
            check(busy == 0 && bank_word(i) == ref_mem[i], "R4 full ECC write one cycle",
                  {8'(busy), bank_word(i)}, {8'd0, ref_mem[i]});
        end
        for (int it = 0; it < 60; it++) begin
            a = $urandom_range(DEPTH-1);
            case ($urandom_range(2))
                0: begin
                    nd = {$urandom, $urandom}; be = 8'($urandom) & 8'hFE;
                    do_write(a, nd, be, busy);
                    ref_mem[a] = bmerge(ref_mem[a], nd, be);
                    check(busy == 3 && bank_word(a) == ref_mem[a], "R8 RMW merge",
                          {8'(busy), bank_word(a)}, {8'd3, ref_mem[a]});
                end
                1: begin
                    p1 = $urandom_range(71);
                    flip(a, p1);
                    do_read(a, d, fx, ft, nm, lat);
                    check(d == ref_mem[a] && fx && !ft && !nm, "R5 random single correction",
                          {5'd0, nm, fx, ft, d}, {8'b010, ref_mem[a]});
                    flip(a, p1);
                end
                default: begin
                    do_read(a, d, fx, ft, nm, lat);
                    check(d == ref_mem[a] && !fx && !ft, "R5 ECC clean read",
                          {6'd0, fx, ft, d}, {8'd0, ref_mem[a]});
                    check(lat == 3, "R7 ECC read latency", 72'(lat), 72'd3);
                end
            endcase
        end

        // R5 / R4 every single stored bit of one word, including both spare groups.
        n0 = nmi_cnt;
        for (int p = 0; p < 72; p++) begin
            flip(0, p);
            do_read(0, d, fx, ft, nm, lat);
            check(d == ref_mem[0] && fx && !ft, $sformatf("R5 R4 flip of stored bit %0d", p),
                  {6'd0, fx, ft, d}, {8'b10, ref_mem[0]});
            flip(0, p);
        end
        @(negedge clk);
        check(nmi_cnt == n0, "R5 no nmi on corrections", 72'(nmi_cnt - n0), 72'd0);

        // R8 correction and merge in the same cycle: flip in kept byte.
        flip(2, 3);
        nd = 64'h1122_3344_5566_7788; be = 8'hFE;
        do_write(2, nd, be, busy);
        ref_mem[2] = bmerge(ref_mem[2], nd, be);
        check(bank_word(2) == ref_mem[2], "R8 kept byte repaired", {8'd0, bank_word(2)}, {8'd0, ref_mem[2]});
        do_read(2, d, fx, ft, nm, lat);
        check(d == ref_mem[2] && !fx && !ft, "R8 rewritten word clean", {6'd0, fx, ft, d}, {8'd0, ref_mem[2]});
        // R8 flip in an overwritten byte.
        flip(2, 60);
        nd = 64'hDEAD_BEEF_0000_0000; be = 8'hF0;
        do_write(2, nd, be, busy);
        ref_mem[2] = bmerge(ref_mem[2], nd, be);
        check(busy == 3 && bank_word(2) == ref_mem[2], "R8 overwritten byte", {8'(busy), bank_word(2)},
              {8'd3, ref_mem[2]});
        do_read(2, d, fx, ft, nm, lat);
        check(d == ref_mem[2] && !fx && !ft, "R8 clean after overwrite", {6'd0, fx, ft, d}, {8'd0, ref_mem[2]});

        // R9 uncorrectable old word aborts the write-back.
        n0 = nmi_cnt;
        flip(9, 1); flip(9, 50);
        old = bank_word(9); slo = bank_lo[9]; shi = bank_hi[9];
        do_write(9, 64'h0, 8'h01, busy);
        @(negedge clk);
        check(bank_lo[9] == slo && bank_hi[9] == shi, "R9 no write-back", {8'd0, bank_word(9)}, {8'd0, old});
        check(nmi_cnt == n0 + 1 && pair_dealloc, "R9 nmi and dealloc", {7'd0, pair_dealloc, 64'(nmi_cnt - n0)},
              {8'd1, 64'd1});

        // R6 double error on read.
        do_reset();
        check(!pair_dealloc, "R10 reset clears dealloc", {71'd0, pair_dealloc}, 72'd0);
        cfg_ecc_en = 1'b1; cfg_pair_matched = 1'b1;
        flip(7, 10); flip(7, 66);
        do_read(7, d, fx, ft, nm, lat);
        @(negedge clk);
        check(ft && nm && !fx && pair_dealloc, "R6 double detected", {68'd0, fx, ft, nm, pair_dealloc}, 72'b0111);
        flip(7, 10); flip(7, 66);
        do_read(7, d, fx, ft, nm, lat);
        check(d == ref_mem[7] && !ft && pair_dealloc, "R6 dealloc sticky", {7'd0, pair_dealloc, d},
              {8'd1, ref_mem[7]});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule